// File: doc/BRIEF.md
# Fuse Array Byte Read Front End

This block puts a register front end before a one-time-programmable fuse array that can only be read. A host reaches two word registers over a simple register bus. Software drives the fuse macro pins one at a time through a control word: an active-low select, a strobe, a load line, an active-low program enable, and a ten-bit byte address. A second word returns the last fuse byte that was fetched.

A read is a sequence of control writes. Software first enters read mode, with select low and both load and program enable high. It then writes the byte address and raises the strobe. The byte appears in the data word on the cycle after that write, and software drops the strobe again. Standby is the control value with select and program enable high and every other bit low; this is also the reset value. If the strobe rises while the pins are in any other setting, nothing is fetched. If the strobe rises while a program operation is being requested, the request is refused and a sticky error flag is set. The array contents are fixed by a formula that the block computes, so the behaviour can be modelled without external data.

Top module: `efuse_rd_if`

## Requirements
- R1: After reset the control word reads 0x0000_0009 (standby), the data word reads 0 and the error flag is clear.
- R2: Control bits 0 (select, active low), 1 (strobe), 2 (load), 3 (program enable, active low) and 15:6 (byte address) store what is written and read back unchanged. Bit 4 and bits 31:16 always read 0. Bit 5 reads the error flag. The control word is at offset 0x0.
- R3: A control write that takes the strobe from 0 to 1 while writing select=0, load=1 and program enable=1 loads the fuse byte at the written address into the data word on the next cycle. Byte a holds ((a mod 256)*37 + 0x5C) mod 256 XOR (a >> 8). This holds at addresses 0 and 1023.
- R4: The data word at offset 0x4 reads the byte in bits 7:0 and zeros in bits 31:8. Bus writes to it are ignored.
- R5: A strobe rise with select high (standby or any other setting), or with load low in read mode, leaves the data word unchanged.
- R6: A control write that keeps the strobe high, even with a new address, does not fetch a byte.
- R7: A strobe rise written with select=0 and program enable=0 programs nothing and leaves the data word unchanged. It sets the error flag (control bit 5), which stays set through later writes that do not clear it.
- R8: Writing a control word with bit 5 set clears the error flag. If the same write is also a refused program request, the flag stays set.
- R9: Offsets other than 0x0 and 0x4 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is selected |

## Verification
The bench aims at the strobe edge. It rewrites the control word with the strobe already high and a new address, and a design that fetched on the level instead of the edge would load the second byte. It drives strobe rises in standby, with load low, with select high and with a program request. A design that decoded the mode loosely would change the data word in one of these cases, or would fail to raise or keep the sticky error. The bench also reads addresses 0 and 1023, where a truncated address field would return the wrong byte. It covers the write in which a clear and a refused program request arrive together, where a design that gave the clear priority would drop the flag.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;

  // bit positions inside the control word
  localparam int CTL_CSN_BIT  = 0;
  localparam int CTL_STB_BIT  = 1;
  localparam int CTL_LOAD_BIT = 2;
  localparam int CTL_PGMN_BIT = 3;
  localparam int CTL_ERR_BIT  = 5;
  localparam int CTL_ADDR_LSB = 6;
  localparam int CTL_WORD_W   = 16;

  // register offsets
  localparam int OFFS_CTRL = 0;
  localparam int OFFS_DOUT = 4;

  typedef struct packed {
    logic pgm_n;
    logic load;
    logic strobe;
    logic csn;
  } fuse_pins_t;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_READ = 2'd1,
    ACC_PROG = 2'd2
  } access_kind_e;

  // preload pattern of the behavioural array
  function automatic logic [7:0] fuse_seed(input logic [9:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd37 + 8'h5C;
    return m ^ {6'b0, a[9:8]};
  endfunction

endpackage

// File: rtl/efr_fuse_rom.sv
module efr_fuse_rom
  import efuse_rd_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 8,
  parameter bit BLANK = 1'b0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);

  generate
    if (BLANK) begin : g_blank
      logic [AW-1:0] unused_addr;
      assign unused_addr = addr;
      assign data        = '0;
    end else begin : g_pattern
      assign data = DW'(fuse_seed(10'(addr)));
    end
  endgenerate

endmodule

// File: rtl/efr_ctrl_reg.sv
module efr_ctrl_reg
  import efuse_rd_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  fuse_pins_t    wr_pins,
  input  logic [AW-1:0] wr_addr,
  output fuse_pins_t    pins_q,
  output logic [AW-1:0] addr_q,
  output logic          strobe_rise
);

  fuse_pins_t    pins_d;
  logic [AW-1:0] addr_d;

  // edge of the strobe bit, seen on the write that raises it
  assign strobe_rise = wr_en & wr_pins.strobe & ~pins_q.strobe;

  always_comb begin
    pins_d = pins_q;
    addr_d = addr_q;
    if (wr_en) begin
      pins_d = wr_pins;
      addr_d = wr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '{pgm_n: 1'b1, load: 1'b0, strobe: 1'b0, csn: 1'b1};
      addr_q <= '0;
    end else if (wr_en) begin
      pins_q <= pins_d;
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/efr_access.sv
module efr_access
  import efuse_rd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_rise,
  input  fuse_pins_t    wr_pins,
  input  logic          err_clr,
  input  logic [DW-1:0] rom_data,
  output logic [DW-1:0] dout_q,
  output logic          err_q,
  output access_kind_e  kind
);

  logic [DW-1:0] dout_d;
  logic          dout_en;
  logic          err_d;
  logic          err_en;

  always_comb begin
    kind = ACC_NONE;
    if (strobe_rise && !wr_pins.csn) begin
      if (!wr_pins.pgm_n)     kind = ACC_PROG;
      else if (wr_pins.load)  kind = ACC_READ;
    end
  end

  always_comb begin
    dout_en = (kind == ACC_READ);
    dout_d  = rom_data;
    err_en  = (kind == ACC_PROG) | err_clr;
    err_d   = (kind == ACC_PROG);   // a refused program wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

endmodule

// File: rtl/efuse_rd_if.sv
module efuse_rd_if
  import efuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int BUS_AW = 4,
  parameter bit BLANK  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam logic [BUS_AW-1:0] A_CTRL   = BUS_AW'(OFFS_CTRL);
  localparam logic [BUS_AW-1:0] A_DOUT   = BUS_AW'(OFFS_DOUT);
  localparam int                ADDR_MSB = CTL_ADDR_LSB + ADDR_W - 1;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // bus decode
  logic          wr_ctrl;
  fuse_pins_t    wr_pins;
  logic [ADDR_W-1:0] wr_addr;
  logic          err_clr;

  assign wr_ctrl = bus_sel & bus_we & (bus_addr == A_CTRL);
  assign wr_pins = '{pgm_n:  bus_wdata[CTL_PGMN_BIT],
                     load:   bus_wdata[CTL_LOAD_BIT],
                     strobe: bus_wdata[CTL_STB_BIT],
                     csn:    bus_wdata[CTL_CSN_BIT]};
  assign wr_addr = bus_wdata[ADDR_MSB:CTL_ADDR_LSB];
  assign err_clr = wr_ctrl & bus_wdata[CTL_ERR_BIT];

  logic [31:0] unused_wdata;
  assign unused_wdata = bus_wdata;

  // control register
  fuse_pins_t        pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic              strobe_rise;

  efr_ctrl_reg #(.AW(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_ctrl),
    .wr_pins     (wr_pins),
    .wr_addr     (wr_addr),
    .pins_q      (pins_q),
    .addr_q      (addr_q),
    .strobe_rise (strobe_rise)
  );

  // array, addressed by the address being written with the strobe
  logic [DATA_W-1:0] rom_data;

  efr_fuse_rom #(.AW(ADDR_W), .DW(DATA_W), .BLANK(BLANK)) u_rom (
    .addr (wr_addr),
    .data (rom_data)
  );

  // access sequencing, data word and error flag
  logic [DATA_W-1:0] dout_q;
  logic              err_q;
  access_kind_e      acc_kind;

  efr_access #(.DW(DATA_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .strobe_rise (strobe_rise),
    .wr_pins     (wr_pins),
    .err_clr     (err_clr),
    .rom_data    (rom_data),
    .dout_q      (dout_q),
    .err_q       (err_q),
    .kind        (acc_kind)
  );

  access_kind_e unused_kind;
  assign unused_kind = acc_kind;

  // read back
  logic [31:0] ctrl_word;

  always_comb begin
    ctrl_word                           = '0;
    ctrl_word[CTL_CSN_BIT]              = pins_q.csn;
    ctrl_word[CTL_STB_BIT]              = pins_q.strobe;
    ctrl_word[CTL_LOAD_BIT]             = pins_q.load;
    ctrl_word[CTL_PGMN_BIT]             = pins_q.pgm_n;
    ctrl_word[CTL_ERR_BIT]              = err_q;
    ctrl_word[ADDR_MSB:CTL_ADDR_LSB]    = addr_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      if (bus_addr == A_CTRL)      bus_rdata = ctrl_word;
      else if (bus_addr == A_DOUT) bus_rdata[DATA_W-1:0] = dout_q;
    end
  end

endmodule

// File: rtl/efr_chk.sv
module efr_chk
  import efuse_rd_pkg::*;
(
  input logic        clk,
  input logic        rst_sync_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        strobe_q,
  input logic [7:0]  dout_q,
  input logic        err_q
);

  logic wr_ctrl, rd_ctrl, rd_dout, rd_other, rise, rd_evt, pg_evt;

  assign wr_ctrl  = bus_sel & bus_we & (bus_addr == 4'h0);
  assign rd_ctrl  = bus_sel & ~bus_we & (bus_addr == 4'h0);
  assign rd_dout  = bus_sel & ~bus_we & (bus_addr == 4'h4);
  assign rd_other = bus_sel & ~bus_we & (bus_addr != 4'h0) & (bus_addr != 4'h4);
  assign rise     = wr_ctrl & bus_wdata[1] & ~strobe_q;
  assign rd_evt   = rise & ~bus_wdata[0] & bus_wdata[2] & bus_wdata[3];
  assign pg_evt   = rise & ~bus_wdata[0] & ~bus_wdata[3];

  p_fetch_byte_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_evt |=> dout_q == fuse_seed($past(bus_wdata[15:6])));

  p_hold_dout_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_evt |=> $stable(dout_q));

  p_dout_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_dout |-> bus_rdata[31:8] == 24'h0);

  p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_ctrl |-> (bus_rdata[31:16] == 16'h0) && !bus_rdata[4]);

  p_prog_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pg_evt |=> err_q);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_q && !(wr_ctrl && bus_wdata[5])) |=> err_q);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_ctrl && bus_wdata[5] && !pg_evt) |=> !err_q);

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_other |-> bus_rdata == 32'h0);

endmodule

bind efuse_rd_if efr_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .strobe_q   (pins_q.strobe),
  .dout_q     (dout_q),
  .err_q      (err_q)
);

// File: tb/efuse_rd_if_test.sv
`timescale 1ns/1ps
module efuse_rd_if_test;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;

  efuse_rd_if uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [15:0] m_ctrl;
  logic        m_err;
  logic [7:0]  m_dout;

  function automatic logic [7:0] ref_byte(input int a);
    int v;
    v = ((a % 256) * 37 + 92) % 256;
    return 8'(v ^ (a / 256));
  endfunction

  function automatic logic [31:0] ctl(input int addr, input logic [3:0] pins);
    return 32'(addr * 64) | {28'h0, pins};
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    logic rise;
    if (a == 4'h0) begin
      rise = d[1] & ~m_ctrl[1];
      if (rise && !d[0] && d[3] && d[2]) m_dout = ref_byte(int'(d[15:6]));
      if (rise && !d[0] && !d[3])        m_err  = 1'b1;
      else if (d[5])                     m_err  = 1'b0;
      m_ctrl = d[15:0] & 16'hFFCF;
    end
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_read(input logic [3:0] a, input string tag);
    exp_item_t it;
    it.addr = a;
    it.tag  = tag;
    if (a == 4'h0)      it.exp = {16'h0, m_ctrl | {10'h0, m_err, 5'h0}};
    else if (a == 4'h4) it.exp = {24'h0, m_dout};
    else                it.exp = 32'h0;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    sb_q.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // monitor: compares a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (bus_sel && !bus_we && sb_q.size() > 0) begin
        exp_item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: offset 0x%0h read 0x%08h expected 0x%08h",
                   it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ctrl = 16'h0009; m_err = 1'b0; m_dout = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    expect_read(4'h0, "R1 ctrl after reset");
    expect_read(4'h4, "R1 dout after reset");

    // R2 enter read mode, read back
    bus_write(4'h0, ctl(0, 4'hC));
    expect_read(4'h0, "R2 read mode readback");

    // R3 fetch address 5
    bus_write(4'h0, ctl(5, 4'hC));
    bus_write(4'h0, ctl(5, 4'hE));
    expect_read(4'h4, "R3 byte at 5");
    bus_write(4'h0, ctl(5, 4'hC));

    // R3 boundaries 1023 and 0
    bus_write(4'h0, ctl(1023, 4'hE));
    expect_read(4'h4, "R3 byte at 1023");
    bus_write(4'h0, ctl(1023, 4'hC));
    bus_write(4'h0, ctl(0, 4'hE));
    expect_read(4'h4, "R3 byte at 0");
    bus_write(4'h0, ctl(0, 4'hC));

    // R3 sweep
    for (int i = 0; i < 8; i++) begin
      int a;
      a = (i * 131 + 17) % 1024;
      bus_write(4'h0, ctl(a, 4'hE));
      expect_read(4'h4, "R3 sweep");
      bus_write(4'h0, ctl(a, 4'hC));
    end

    // R2 all ones: reserved bits read zero; strobe rise with csn high (R5)
    bus_write(4'h0, 32'hFFFF_FFFF);
    expect_read(4'h0, "R2 reserved bits zero");
    expect_read(4'h4, "R5 select high no fetch");

    // R5 standby then strobe
    bus_write(4'h0, ctl(0, 4'h9));
    bus_write(4'h0, ctl(300, 4'hB));
    expect_read(4'h4, "R5 standby strobe");
    // R5 read mode without load
    bus_write(4'h0, ctl(300, 4'h8));
    bus_write(4'h0, ctl(300, 4'hA));
    expect_read(4'h4, "R5 load low strobe");

    // R6 strobe held high, new address
    bus_write(4'h0, ctl(7, 4'hC));
    bus_write(4'h0, ctl(7, 4'hE));
    bus_write(4'h0, ctl(9, 4'hE));
    expect_read(4'h4, "R6 held strobe no refetch");
    expect_read(4'h0, "R6 ctrl keeps new address");

    // R7 program attempt
    bus_write(4'h0, ctl(3, 4'h0));
    bus_write(4'h0, ctl(3, 4'h2));
    expect_read(4'h4, "R7 dout unchanged by program");
    expect_read(4'h0, "R7 error flag set");
    bus_write(4'h0, ctl(0, 4'h9));
    expect_read(4'h0, "R7 error flag sticky");

    // R4 writes to data word ignored
    bus_write(4'h4, 32'hFFFF_FFFF);
    expect_read(4'h4, "R4 dout write ignored");

    // R9 unmapped offsets
    expect_read(4'h8, "R9 unmapped read zero");
    bus_write(4'h8, 32'h0000_FFFF);
    bus_write(4'hC, 32'h0000_0022);
    expect_read(4'h0, "R9 unmapped write no effect ctrl");
    expect_read(4'h4, "R9 unmapped write no effect dout");

    // R8 clear, then clear together with program request
    bus_write(4'h0, ctl(0, 4'h9) | 32'h20);
    expect_read(4'h0, "R8 error cleared");
    bus_write(4'h0, ctl(0, 4'h0));
    bus_write(4'h0, ctl(0, 4'h2) | 32'h20);
    expect_read(4'h0, "R8 program wins over clear");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule